// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block owns a small shared word-addressed memory and serves several requester ports. Each port can issue a plain load, a plain store, test-and-set, swap or compare-and-swap. The block grants one port at a time. The granted operation reads the addressed word and, when the operation calls for it, writes the new word. That read and write finish before any other port is granted. No access from another port can therefore slip between the read and the write.

Each response returns the word the memory held before the operation. Compare-and-swap also reports whether the swap took place. With this, software can build locks: a swap of 1 that returns 0 takes the lock, and a plain store of 0 releases it.

Each port raises a valid signal with its command and holds it until the block answers with ready. The block accepts at most one command per two cycles. A one-cycle response pulse on the requesting port follows each accepted command.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads as zero, no response is pending, and no port sees ready while its valid is low.
- R2: Opcode 0 (load) returns the addressed word and leaves memory unchanged.
- R3: Opcode 1 (store) writes the write-data operand to the address and returns the previous word.
- R4: Opcode 2 (test-and-set) returns the previous word and writes the value 1 to the address.
- R5: Opcode 3 (swap) returns the previous word and writes the write-data operand in its place.
- R6: Opcode 4 (compare-and-swap) whose compare operand equals the current word writes the write-data operand, returns the previous word and reports ok = 1.
- R7: Compare-and-swap whose compare operand differs from the current word leaves memory unchanged, returns the current word and reports ok = 0.
- R8: Every opcode other than compare-and-swap reports ok = 1.
- R9: A command is accepted on a rising edge where the port's valid and ready are both high, and ready is high on at most one port at a time.
- R10: When the block is idle, ready goes to the first port with valid high, searching upward from the port after the one granted last and wrapping around. After reset the search starts at port 0.
- R11: A command accepted on edge k gives a one-cycle rsp_valid pulse on that port only, in the cycle after edge k+1, with rsp_data and rsp_ok valid in the same cycle.
- R12: After an acceptance, ready stays low on every port in the next cycle, so the operation's read and write complete before any other command is accepted.
- R13: Opcodes 5 to 7 behave as a load: they return the word, write nothing and report ok = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Per-port command valid |
| req_ready | output | NP | Per-port command accept |
| req_op | input | NP*3 | Per-port opcode, 3 bits each |
| req_addr | input | NP*AW | Per-port word address |
| req_wdata | input | NP*DW | Per-port data to store, swap in, or write on compare match |
| req_cmp | input | NP*DW | Per-port compare operand for compare-and-swap |
| rsp_valid | output | NP | Per-port one-cycle response pulse |
| rsp_data | output | DW | Word held before the operation |
| rsp_ok | output | 1 | Compare-and-swap outcome; 1 for other opcodes |

## Verification
Directed sequences run each opcode on its own. Back-to-back test-and-set on one address separates the first return of 0 from the later returns of 1. A compare-and-swap with a stale compare value separates the fail path from the match path. A lock sequence between two ports checks that a second swap of 1 is refused until a store of 0 releases the lock. All three ports then request at once, repeatedly and with random opcodes, on a few colliding addresses. This exercises the round-robin order and the gap that keeps each operation indivisible. A bench reference model predicts ready, responses and memory contents every cycle, so a lost update or a lock granted twice shows up as a data mismatch.

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int NP = 3,
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    req_valid,
  output logic [NP-1:0]    req_ready,
  input  logic [NP*3-1:0]  req_op,
  input  logic [NP*AW-1:0] req_addr,
  input  logic [NP*DW-1:0] req_wdata,
  input  logic [NP*DW-1:0] req_cmp,
  output logic [NP-1:0]    rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_ok
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = (NP > 1) ? $clog2(NP) : 1;
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_TAS = 3'd2, OP_SWP = 3'd3, OP_CAS = 3'd4;

  logic [DW-1:0] mem [DEPTH];
  logic          busy;
  logic [PW-1:0] port, last, pick;
  logic [2:0]    op;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd, cmpv, rd_word, nw;
  logic          found, do_wr, ok;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NP; k++) begin
      if (!found && req_valid[PW'((int'(last) + k) % NP)]) begin
        found = 1'b1;
        pick  = PW'((int'(last) + k) % NP);
      end
    end
  end

  assign req_ready = (!busy && found) ? (NP'(1) << pick) : '0;
  assign rd_word   = mem[addr];

  always_comb begin
    do_wr = 1'b0;
    nw    = wd;
    case (op)
      OP_ST, OP_SWP: do_wr = 1'b1;
      OP_TAS: begin do_wr = 1'b1; nw = DW'(1); end
      OP_CAS: do_wr = (rd_word == cmpv);
      default: do_wr = 1'b0;
    endcase
  end
  assign ok = (op == OP_CAS) ? (rd_word == cmpv) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      busy      <= 1'b0;
      port      <= '0;
      last      <= PW'(NP - 1);
      op        <= OP_LD;
      addr      <= '0;
      wd        <= '0;
      cmpv      <= '0;
      rsp_valid <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= '0;
      if (busy) begin
        if (do_wr) mem[addr] <= nw;
        rsp_valid <= NP'(1) << port;
        rsp_data  <= rd_word;
        rsp_ok    <= ok;
        busy      <= 1'b0;
      end else if (found) begin
        busy <= 1'b1;
        port <= pick;
        last <= pick;
        op   <= req_op[pick*3 +: 3];
        addr <= req_addr[pick*AW +: AW];
        wd   <= req_wdata[pick*DW +: DW];
        cmpv <= req_cmp[pick*DW +: DW];
      end
    end
  end

  p_ready_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  p_gap_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> (req_ready == '0));
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & req_ready)) |=> ##1 ($countones(rsp_valid) == 1));
  p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (rsp_valid == '0));
  p_tas_sets_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_TAS) |=> (mem[$past(addr)] == DW'(1)));
  p_cas_fail_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_CAS && rd_word != cmpv) |=> (mem[$past(addr)] == $past(rd_word) && !rsp_ok));
  p_load_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_LD) |=> (mem[$past(addr)] == $past(rd_word)));
endmodule

// File: tb/atomic_mem_unit_test.sv
module atomic_mem_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3, AW = 6, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0, req_ready, rsp_valid;
  logic [NP*3-1:0] req_op = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*DW-1:0] req_wdata = '0, req_cmp = '0;
  logic [DW-1:0] rsp_data;
  logic rsp_ok;

  int total = 0, bad = 0;
  bit done = 0;

  atomic_mem_unit #(.NP(NP), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit cond, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  logic [DW-1:0] mmem [1<<AW];
  bit mb;
  int mp, ml, mop, ma;
  logic [DW-1:0] mwd, mcmp, mdata;
  logic [NP-1:0] mrv;
  bit mok;
  string dtag, otag;

  always @(negedge clk) begin
    int ew;
    logic [DW-1:0] old;
    logic [NP-1:0] er;
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mmem[i] = '0;
      mb = 0; ml = NP - 1; mrv = '0; mok = 0; mdata = '0;
      check(rsp_valid == '0, "R1 rsp_valid in reset", DW'(rsp_valid), 0);
    end else begin
      ew = -1;
      if (!mb)
        for (int k = 1; k <= NP; k++)
          if (ew < 0 && req_valid[(ml + k) % NP]) ew = (ml + k) % NP;
      er = (ew >= 0) ? (NP'(1) << ew) : '0;
      check(req_ready == er, "R9 R10 R12 R1 ready", DW'(req_ready), DW'(er));
      check(rsp_valid == mrv, "R11 rsp_valid", DW'(rsp_valid), DW'(mrv));
      if (mrv != '0) begin
        check(rsp_data == mdata, dtag, rsp_data, mdata);
        check(rsp_ok == mok, otag, DW'(rsp_ok), DW'(mok));
      end
      mrv = '0;
      if (mb) begin
        old = mmem[ma];
        mdata = old; mok = 1; mrv = NP'(1) << mp; otag = "R8 ok";
        case (mop)
          0: dtag = "R2 load data";
          1: begin dtag = "R3 store old data"; mmem[ma] = mwd; end
          2: begin dtag = "R4 tas old data"; mmem[ma] = 1; end
          3: begin dtag = "R5 swap old data"; mmem[ma] = mwd; end
          4: begin
            if (old == mcmp) begin mmem[ma] = mwd; dtag = "R6 cas match data"; otag = "R6 cas ok"; end
            else begin mok = 0; dtag = "R7 cas fail data"; otag = "R7 cas ok"; end
          end
          default: dtag = "R13 unused op data";
        endcase
        mb = 0;
      end else if (ew >= 0) begin
        mb = 1; mp = ew; ml = ew;
        mop = int'(req_op[ew*3 +: 3]);
        ma = int'(req_addr[ew*AW +: AW]);
        mwd = req_wdata[ew*DW +: DW];
        mcmp = req_cmp[ew*DW +: DW];
      end
    end
  end

  task automatic issue(input int p, input int op, input int a, input logic [DW-1:0] w, input logic [DW-1:0] c);
    @(posedge clk); #1;
    req_op[p*3 +: 3] = 3'(op);
    req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = w;
    req_cmp[p*DW +: DW] = c;
    req_valid[p] = 1'b1;
    @(negedge clk);
    while (!req_ready[p]) @(negedge clk);
    @(posedge clk); #1;
    req_valid[p] = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(posedge clk);
  endtask

  task automatic rand_port(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      int op;
      op = ($urandom % 10 == 0) ? 5 + int'($urandom % 3) : int'($urandom % 5);
      issue(p, op, int'($urandom % 4), ($urandom % 3 == 0) ? 32'd0 : $urandom % 4, $urandom % 4);
      if ($urandom % 3 == 0) @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: fresh memory reads zero
    issue(0, 0, 0, 0, 0); issue(1, 0, 63, 0, 0); issue(2, 0, 17, 0, 0);
    // R3 R2
    issue(0, 1, 5, 32'hDEADBEEF, 0); issue(1, 0, 5, 0, 0);
    // R4: first returns 0, then 1
    issue(2, 2, 7, 0, 0); issue(0, 2, 7, 0, 0); issue(1, 0, 7, 0, 0);
    // R5
    issue(1, 3, 5, 32'h1234, 0); issue(2, 0, 5, 0, 0);
    // lock idiom with swap of 1 and release by store of 0
    issue(0, 3, 9, 1, 0); issue(1, 3, 9, 1, 0); issue(0, 1, 9, 0, 0); issue(1, 3, 9, 1, 0);
    // R6 R7
    issue(2, 4, 5, 32'hCAFE, 32'h1234); issue(0, 4, 5, 32'hBAD, 32'h1234); issue(1, 0, 5, 0, 0);
    // R13
    issue(0, 6, 5, 32'h55, 0); issue(0, 7, 5, 32'h66, 32'hCAFE); issue(2, 0, 5, 0, 0);
    wait_idle();
    // R10 contention: all ports test-and-set one word together
    fork
      issue(0, 2, 20, 0, 0);
      issue(1, 2, 20, 0, 0);
      issue(2, 2, 20, 0, 0);
    join
    wait_idle();
    fork
      rand_port(0, 200);
      rand_port(1, 200);
      rand_port(2, 200);
    join
    wait_idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule